// File: doc/BRIEF.md
# Serial Bus Control Signal Unit

This unit watches and drives the control conditions of a two-wire serial bus made of a clock line and a shared open-drain data line. It recognises the conditions as data-line transitions that happen while the clock line is high. A rise of the data line is a bus release and a fall is a command. It keeps a sticky detect flag for release, command and acknowledge. It also records whether the most recent command came straight after a release, which means the next byte is an address, or not, which means it is a command.

On the master side, a write to a trigger bit makes the unit produce a release or a command on the data line. It times the edge against the bus clock so that the edge lands inside a clock-high phase. On the receiving side, the unit can pull the data line low as an acknowledge after each 8-bit transfer, either automatically or when software asks. It can then keep the line low as a busy hold until software clears the busy enable and starts a new transfer. When the unit is not holding the line, it reports ready. The data line is only ever pulled low; a released line floats high.

Top module: `sbc_ctrl`

## Requirements
- R1: When the data line rises while the synchronized clock line is high, the release flag (det_flags_o bit 0) is 1 and the command flag (bit 1) is 0 three system clocks after the rise reaches the input.
- R2: When the data line falls while the synchronized clock line is high, the command flag (det_flags_o bit 1) is 1 three system clocks after the fall reaches the input.
- R3: Data-line transitions while the clock line is low change no detect flag.
- R4: Writing flag_clr_we_i with a 1 in a bit of flag_clr_i clears that flag (bit 0 release, bit 1 command, bit 2 acknowledge). A condition detected in the same cycle keeps the flag at 1.
- R5: Writing ctl_wdata_i bit 0 requests a release. The unit waits for the clock line to be low, pulls the data line low, and lets it go once the clock line is seen high. trig_busy_o bit 0 reads 1 from the cycle after the write until the line is let go.
- R6: Writing ctl_wdata_i bit 1 requests a command. The unit waits until both lines are high, pulls the data line low, and holds it until the clock line is seen low. trig_busy_o bit 1 reads 1 until then.
- R7: is_addr_o is updated on each detected command. It is 1 when the previous detected condition was a release and 0 when it was a command. When both trigger bits are written together, the release is produced first.
- R8: With auto-acknowledge enabled (ctl_wdata_i bit 3), an xfer_done_i pulse with rx_dir_i = 1 pulls the data line low from the next cycle. The pull lasts until the clock line has been seen high and then low.
- R9: Writing ctl_wdata_i bit 2 produces exactly one acknowledge with the same timing as R8.
- R10: After an xfer_done_i pulse, the acknowledge flag (bit 2) is set at the first synchronized rising edge of the clock line if the data line is low at that moment. It stays 0 if the line is high.
- R11: With busy enable (ctl_wdata_i bit 4) set, the pull continues after the acknowledge. It ends only in a cycle where busy enable is 0 and xfer_start_i is 1.
- R12: ready_o is 1 exactly when no acknowledge or busy pull is active. bus_dat_pull_o = 1 means the data line is pulled low.
- R13: After reset, all detect flags, is_addr_o, trig_busy_o and bus_dat_pull_o are 0, and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock line, asynchronous |
| bus_dat_i | input | 1 | Resolved data line level, asynchronous |
| bus_dat_pull_o | output | 1 | 1 pulls the data line low |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 5 | {busy_en, auto_ack_en, ack_trig, cmd_trig, rel_trig} |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_i | input | 3 | Write-1-to-clear mask {ack, cmd, rel} |
| xfer_done_i | input | 1 | Pulse: an 8-bit transfer finished |
| rx_dir_i | input | 1 | 1 when the finished transfer was a reception |
| xfer_start_i | input | 1 | Pulse: shift data register written |
| det_flags_o | output | 3 | Detect flags {ack, cmd, rel} |
| is_addr_o | output | 1 | Last command marks address data |
| trig_busy_o | output | 2 | {cmd, rel} generation pending or active |
| ready_o | output | 1 | Not holding the data line |

## Verification
The assertions assume a clock line whose high and low phases each last longer than the synchronizer delay plus a few cycles. A requested release or command can only finish if its edge reaches the detector while the clock is still high. They also assume that xfer_done_i arrives while the clock line is low. The stimulus holds each bus clock phase for at least four system clocks, uses a 16-cycle half period when the unit generates conditions itself, and sends transfer-done pulses only with the clock line low. External data edges are made only when a specific condition is intended.

// File: rtl/sbc_pkg.sv
// Shared types and bit positions for the serial bus control unit.
// Assumes: the register-side bit positions below are fixed by the block's interface.
package sbc_pkg;

    // Control write bit positions
    localparam int CTL_W    = 5;
    localparam int CB_REL   = 0;
    localparam int CB_CMD   = 1;
    localparam int CB_ACK   = 2;
    localparam int CB_AUTO  = 3;
    localparam int CB_BUSY  = 4;

    // Detect flag bit positions
    localparam int FLAG_W   = 3;
    localparam int FB_REL   = 0;
    localparam int FB_CMD   = 1;
    localparam int FB_ACK   = 2;

    // Master condition generator states
    typedef enum logic [2:0] {
        MG_IDLE,
        MG_REL_WLO,
        MG_REL_LO,
        MG_CMD_WHI,
        MG_CMD_LO
    } mst_st_t;

    // Acknowledge / busy driver states
    typedef enum logic [1:0] {
        AK_IDLE,
        AK_WHI,
        AK_HI,
        AK_BUSY
    } ack_st_t;

    // Synchronized view of the two bus lines
    typedef struct packed {
        logic clk_hi;
        logic clk_rise;
        logic dat_hi;
        logic dat_rise;
        logic dat_fall;
    } bus_view_t;

endpackage

// File: rtl/sbc_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// derives levels and edges from the last two synchronized samples.
// Assumes: both lines idle high; STAGES >= 2 flops before the history flop.
module sbc_sync
    import sbc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_clk_i,
    input  logic      bus_dat_i,
    output bus_view_t view_o
);

    localparam int LINES  = 2;
    localparam int PIPE_W = STAGES + 1;
    localparam int CUR    = STAGES - 1;
    localparam int PRV    = STAGES;

    logic [LINES-1:0] raw;
    assign raw = {bus_dat_i, bus_clk_i};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [PIPE_W-1:0] pipe;
            // Shift the line through the synchronizer and history flop
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[PIPE_W-2:0], raw[g]};
            end
        end
    endgenerate

    logic k_cur, k_prv, d_cur, d_prv;
    assign k_cur = g_line[0].pipe[CUR];
    assign k_prv = g_line[0].pipe[PRV];
    assign d_cur = g_line[1].pipe[CUR];
    assign d_prv = g_line[1].pipe[PRV];

    // Form the condition view: data edges count only with clock high in both samples
    always_comb begin
        view_o.clk_hi   = k_cur;
        view_o.clk_rise = k_cur & ~k_prv;
        view_o.dat_hi   = d_cur;
        view_o.dat_rise = d_cur & ~d_prv & k_cur & k_prv;
        view_o.dat_fall = ~d_cur & d_prv & k_cur & k_prv;
    end

endmodule

// File: rtl/sbc_flags.sv
// Sticky detect flags for release, command and acknowledge, plus the
// address/command marker for the data following a command.
// Assumes: clear mask is write-1-to-clear; a detection beats a clear.
module sbc_flags
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_view_t         view_i,
    input  logic              xfer_done_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              is_addr_o
);

    logic              armed;
    logic              last_rel;
    logic              ack_set;
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;
    logic [FLAG_W-1:0] flags_nx;

    assign ack_set = armed & view_i.clk_rise & ~view_i.dat_hi;

    // Gather set and clear requests per flag
    always_comb begin
        set_v          = '0;
        set_v[FB_REL]  = view_i.dat_rise;
        set_v[FB_CMD]  = view_i.dat_fall;
        set_v[FB_ACK]  = ack_set;
        clr_v          = clr_we_i ? clr_i : '0;
        clr_v[FB_CMD]  = clr_v[FB_CMD] | view_i.dat_rise;
    end

    // Next flag value: set wins over clear
    genvar f;
    generate
        for (f = 0; f < FLAG_W; f++) begin : g_flag
            assign flags_nx[f] = set_v[f] | (flags_o[f] & ~clr_v[f]);
        end
    endgenerate

    // Register the flags
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= flags_nx;
    end

    // Arm the acknowledge sample after a transfer, disarm at the next clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b0;
        else if (xfer_done_i)      armed <= 1'b1;
        else if (view_i.clk_rise)  armed <= 1'b0;
    end

    // Track whether the latest condition was a release, mark the data type on command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rel  <= 1'b0;
            is_addr_o <= 1'b0;
        end else if (view_i.dat_rise) begin
            last_rel  <= 1'b1;
        end else if (view_i.dat_fall) begin
            last_rel  <= 1'b0;
            is_addr_o <= last_rel;
        end
    end

    p_rel_clears_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        view_i.dat_rise |=> (flags_o[FB_REL] && !flags_o[FB_CMD]));

    p_cmd_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        view_i.dat_fall |=> flags_o[FB_CMD]);

    p_quiet_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_i.clk_hi && !clr_we_i) |=> $stable(flags_o));

    p_w1c_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_i[FB_CMD] && !view_i.dat_fall) |=> !flags_o[FB_CMD]);

    p_ack_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && view_i.clk_rise && !view_i.dat_hi) |=> flags_o[FB_ACK]);

endmodule

// File: rtl/sbc_mst_gen.sv
// Master-side generator for release and command conditions.
// Release: wait clock low, pull low, let go once clock is high.
// Command: wait clock and data high, pull low, let go once clock is low.
// Assumes: clock phases outlast the synchronizer delay.
module sbc_mst_gen
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_hi_i,
    input  logic dat_hi_i,
    input  logic rel_req_i,
    input  logic cmd_req_i,
    output logic drive_o,
    output logic rel_busy_o,
    output logic cmd_busy_o
);

    mst_st_t st;
    logic    rel_pend;
    logic    cmd_pend;
    logic    take_rel;
    logic    take_cmd;
    logic    rel_drv;
    logic    cmd_drv;

    assign take_rel = (st == MG_IDLE) & rel_pend;
    assign take_cmd = (st == MG_IDLE) & ~rel_pend & cmd_pend;

    // Hold requests until the generator picks them up; a new write wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_pend <= 1'b0;
            cmd_pend <= 1'b0;
        end else begin
            if (rel_req_i)     rel_pend <= 1'b1;
            else if (take_rel) rel_pend <= 1'b0;
            if (cmd_req_i)     cmd_pend <= 1'b1;
            else if (take_cmd) cmd_pend <= 1'b0;
        end
    end

    // Step through the condition sequence against the bus clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= MG_IDLE;
        end else begin
            unique case (st)
                MG_IDLE:    if (take_rel) st <= MG_REL_WLO;
                            else if (take_cmd) st <= MG_CMD_WHI;
                MG_REL_WLO: if (!clk_hi_i) st <= MG_REL_LO;
                MG_REL_LO:  if (clk_hi_i) st <= MG_IDLE;
                MG_CMD_WHI: if (clk_hi_i && dat_hi_i) st <= MG_CMD_LO;
                MG_CMD_LO:  if (!clk_hi_i) st <= MG_IDLE;
                default:    st <= MG_IDLE;
            endcase
        end
    end

    assign rel_drv    = (st == MG_REL_LO);
    assign cmd_drv    = (st == MG_CMD_LO);
    assign drive_o    = rel_drv | cmd_drv;
    assign rel_busy_o = rel_pend | (st == MG_REL_WLO) | rel_drv;
    assign cmd_busy_o = cmd_pend | (st == MG_CMD_WHI) | cmd_drv;

    p_rel_let_go_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_drv) |-> $past(clk_hi_i));

    p_rel_pull_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_drv) |-> $past(!clk_hi_i));

    p_cmd_pull_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_drv) |-> $past(clk_hi_i && dat_hi_i));

endmodule

// File: rtl/sbc_ack_gen.sv
// Acknowledge and busy driver: pulls the data line low for one bus clock
// period after a transfer, then optionally holds it low as busy.
// Assumes: start requests arrive while the bus clock is low.
module sbc_ack_gen
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_hi_i,
    input  logic start_ack_i,
    input  logic busy_en_i,
    input  logic xfer_start_i,
    output logic drive_o,
    output logic ready_o
);

    ack_st_t st;
    logic    busy_exit;

    assign busy_exit = ~busy_en_i & xfer_start_i;

    // Sequence acknowledge through one clock high phase, then busy or idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= AK_IDLE;
        end else begin
            unique case (st)
                AK_IDLE: if (start_ack_i) st <= AK_WHI;
                AK_WHI:  if (clk_hi_i) st <= AK_HI;
                AK_HI:   if (!clk_hi_i) st <= busy_en_i ? AK_BUSY : AK_IDLE;
                AK_BUSY: if (busy_exit) st <= AK_IDLE;
                default: st <= AK_IDLE;
            endcase
        end
    end

    assign drive_o = (st != AK_IDLE);
    assign ready_o = (st == AK_IDLE);

    p_ack_ends_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_o) |-> $past(!clk_hi_i || st == AK_BUSY));

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == AK_BUSY && !busy_exit) |=> drive_o);

    p_ack_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ack_i && st == AK_IDLE) |=> (drive_o && !ready_o));

endmodule

// File: rtl/sbc_ctrl.sv
// Top of the serial bus control unit: synchronizer, detect flags, master
// condition generator and acknowledge/busy driver, with control bits.
// Assumes: bus_dat_i is the resolved line level including this unit's pull.
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    output logic              bus_dat_pull_o,
    input  logic              ctl_we_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic              flag_clr_we_i,
    input  logic [FLAG_W-1:0] flag_clr_i,
    input  logic              xfer_done_i,
    input  logic              rx_dir_i,
    input  logic              xfer_start_i,
    output logic [FLAG_W-1:0] det_flags_o,
    output logic              is_addr_o,
    output logic [1:0]        trig_busy_o,
    output logic              ready_o
);

    bus_view_t view;
    logic      auto_en;
    logic      busy_en;
    logic      start_ack;
    logic      mst_drive;
    logic      ack_drive;
    logic      rel_busy;
    logic      cmd_busy;

    // Hold the enable bits written through the control port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en <= 1'b0;
            busy_en <= 1'b0;
        end else if (ctl_we_i) begin
            auto_en <= ctl_wdata_i[CB_AUTO];
            busy_en <= ctl_wdata_i[CB_BUSY];
        end
    end

    // Acknowledge starts automatically after a reception or on request
    assign start_ack = (xfer_done_i & rx_dir_i & auto_en)
                     | (ctl_we_i & ctl_wdata_i[CB_ACK]);

    sbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_clk_i (bus_clk_i),
        .bus_dat_i (bus_dat_i),
        .view_o    (view)
    );

    sbc_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .view_i      (view),
        .xfer_done_i (xfer_done_i),
        .clr_we_i    (flag_clr_we_i),
        .clr_i       (flag_clr_i),
        .flags_o     (det_flags_o),
        .is_addr_o   (is_addr_o)
    );

    sbc_mst_gen u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_hi_i   (view.clk_hi),
        .dat_hi_i   (view.dat_hi),
        .rel_req_i  (ctl_we_i & ctl_wdata_i[CB_REL]),
        .cmd_req_i  (ctl_we_i & ctl_wdata_i[CB_CMD]),
        .drive_o    (mst_drive),
        .rel_busy_o (rel_busy),
        .cmd_busy_o (cmd_busy)
    );

    sbc_ack_gen u_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_hi_i     (view.clk_hi),
        .start_ack_i  (start_ack),
        .busy_en_i    (busy_en),
        .xfer_start_i (xfer_start_i),
        .drive_o      (ack_drive),
        .ready_o      (ready_o)
    );

    assign bus_dat_pull_o = mst_drive | ack_drive;
    assign trig_busy_o    = {cmd_busy, rel_busy};

    p_reset_quiet_r13: assert property (@(posedge clk)
        !rst_n |=> (!bus_dat_pull_o && ready_o && det_flags_o == '0));

endmodule

// File: tb/sbc_ctrl_tb.sv
module sbc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BUS_HALF   = 16;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b1;
    logic       bext = 1'b1;
    logic       brun = 1'b0;
    logic       pull;
    logic       line;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wd = '0;
    logic       clr_we = 1'b0;
    logic [2:0] clr_m = '0;
    logic       xdone = 1'b0;
    logic       rxdir = 1'b0;
    logic       xstart = 1'b0;
    logic [2:0] flags;
    logic       is_addr;
    logic [1:0] trig;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit live = 0;
    bit done_run = 0;

    assign line = bext & ~pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_clk_i      (bclk),
        .bus_dat_i      (line),
        .bus_dat_pull_o (pull),
        .ctl_we_i       (ctl_we),
        .ctl_wdata_i    (ctl_wd),
        .flag_clr_we_i  (clr_we),
        .flag_clr_i     (clr_m),
        .xfer_done_i    (xdone),
        .rx_dir_i       (rxdir),
        .xfer_start_i   (xstart),
        .det_flags_o    (flags),
        .is_addr_o      (is_addr),
        .trig_busy_o    (trig),
        .ready_o        (ready)
    );

    // ---------------- behavioural reference model ----------------
    int k_h[3];
    int d_h[3];
    int m_rel, m_cmd, m_ack, m_addr, m_last_rel, m_armed;
    int m_relp, m_cmdp, m_mph, m_aph, m_auto, m_busy, m_pull;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (k_h[i]) begin k_h[i] = 1; d_h[i] = 1; end
            m_rel = 0; m_cmd = 0; m_ack = 0; m_addr = 0; m_last_rel = 0; m_armed = 0;
            m_relp = 0; m_cmdp = 0; m_mph = 0; m_aph = 0; m_auto = 0; m_busy = 0; m_pull = 0;
            live = 1;
        end else begin
            int ln, rs, fl, cr, aset, clr0, clr1, clr2;
            int n_relp, n_cmdp, n_mph, n_aph, st_ack;
            ln   = (bext && !m_pull) ? 1 : 0;
            rs   = (d_h[1] == 1 && d_h[2] == 0 && k_h[1] == 1 && k_h[2] == 1) ? 1 : 0;
            fl   = (d_h[1] == 0 && d_h[2] == 1 && k_h[1] == 1 && k_h[2] == 1) ? 1 : 0;
            cr   = (k_h[1] == 1 && k_h[2] == 0) ? 1 : 0;
            aset = (m_armed == 1 && cr == 1 && d_h[1] == 0) ? 1 : 0;
            clr0 = (clr_we && clr_m[0]) ? 1 : 0;
            clr1 = (clr_we && clr_m[1]) ? 1 : 0;
            clr2 = (clr_we && clr_m[2]) ? 1 : 0;
            // flags
            if (rs == 1) m_rel = 1; else if (clr0 == 1) m_rel = 0;
            if (fl == 1) m_cmd = 1; else if (rs == 1 || clr1 == 1) m_cmd = 0;
            if (aset == 1) m_ack = 1; else if (clr2 == 1) m_ack = 0;
            if (fl == 1) m_addr = m_last_rel;
            if (rs == 1) m_last_rel = 1; else if (fl == 1) m_last_rel = 0;
            if (xdone) m_armed = 1; else if (cr == 1) m_armed = 0;
            // master generator
            n_relp = m_relp; n_cmdp = m_cmdp; n_mph = m_mph;
            case (m_mph)
                0: if (m_relp == 1) begin n_mph = 1; n_relp = 0; end
                   else if (m_cmdp == 1) begin n_mph = 3; n_cmdp = 0; end
                1: if (k_h[1] == 0) n_mph = 2;
                2: if (k_h[1] == 1) n_mph = 0;
                3: if (k_h[1] == 1 && d_h[1] == 1) n_mph = 4;
                4: if (k_h[1] == 0) n_mph = 0;
                default: n_mph = 0;
            endcase
            if (ctl_we && ctl_wd[0]) n_relp = 1;
            if (ctl_we && ctl_wd[1]) n_cmdp = 1;
            // acknowledge / busy
            st_ack = ((xdone && rxdir && m_auto == 1) || (ctl_we && ctl_wd[2])) ? 1 : 0;
            n_aph = m_aph;
            case (m_aph)
                0: if (st_ack == 1) n_aph = 1;
                1: if (k_h[1] == 1) n_aph = 2;
                2: if (k_h[1] == 0) n_aph = (m_busy == 1) ? 3 : 0;
                3: if (m_busy == 0 && xstart) n_aph = 0;
                default: n_aph = 0;
            endcase
            if (ctl_we) begin m_auto = ctl_wd[3]; m_busy = ctl_wd[4]; end
            m_relp = n_relp; m_cmdp = n_cmdp; m_mph = n_mph; m_aph = n_aph;
            k_h[2] = k_h[1]; k_h[1] = k_h[0]; k_h[0] = bclk;
            d_h[2] = d_h[1]; d_h[1] = d_h[0]; d_h[0] = ln;
            m_pull = (m_mph == 2 || m_mph == 4 || m_aph != 0) ? 1 : 0;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done_run) begin
            chk(flags[0], m_rel,  "R1 rel flag vs model");
            chk(flags[1], m_cmd,  "R2 cmd flag vs model");
            chk(flags[2], m_ack,  "R10 ack flag vs model");
            chk(is_addr,  m_addr, "R7 is_addr vs model");
            chk(trig[0],  (m_relp == 1 || m_mph == 1 || m_mph == 2) ? 1 : 0, "R5 rel busy vs model");
            chk(trig[1],  (m_cmdp == 1 || m_mph == 3 || m_mph == 4) ? 1 : 0, "R6 cmd busy vs model");
            chk(pull,     m_pull, "R8 pull vs model");
            chk(ready,    (m_aph == 0) ? 1 : 0, "R12 ready vs model");
        end
    end

    task automatic finish_run();
        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done_run) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // Free-running bus clock when enabled
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (brun) begin
                cnt++;
                if (cnt == BUS_HALF) begin bclk = ~bclk; cnt = 0; end
            end else cnt = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [4:0] w);
        ctl_we = 1'b1; ctl_wd = w; tick(1); ctl_we = 1'b0; ctl_wd = '0;
    endtask

    task automatic clr_flags(input logic [2:0] m);
        clr_we = 1'b1; clr_m = m; tick(1); clr_we = 1'b0; clr_m = '0;
    endtask

    task automatic pulse_done(input logic dir);
        xdone = 1'b1; rxdir = dir; tick(1); xdone = 1'b0; rxdir = 1'b0;
    endtask

    task automatic pulse_start();
        xstart = 1'b1; tick(1); xstart = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk(flags, 0, "R13 flags after reset");
        chk(pull, 0, "R13 no pull after reset");
        chk(ready, 1, "R13 ready after reset");
        chk(trig, 0, "R13 trig after reset");

        // External release: data low under clock low, clock high, then data rises
        bclk = 0; tick(4); bext = 0; tick(4); bclk = 1; tick(4); bext = 1; tick(6);
        chk(flags[0], 1, "R1 release detected");
        chk(flags[1], 0, "R1 command flag clear");
        // Command right after release
        bext = 0; tick(6);
        chk(flags[1], 1, "R2 command detected");
        chk(is_addr, 1, "R7 command after release marks address");
        // Release again clears command flag
        bext = 1; tick(6);
        chk(flags[1], 0, "R1 release clears command flag");
        bext = 0; tick(6);
        // Edges under clock low are ignored
        clr_flags(3'b111); tick(2);
        bclk = 0; tick(4); bext = 1; tick(4); bext = 0; tick(4); bext = 1; tick(6);
        chk(flags, 0, "R3 no flag from clock-low edges");
        // Command without preceding release
        bclk = 1; tick(4); bext = 0; tick(6);
        chk(flags[1], 1, "R2 second command detected");
        chk(is_addr, 0, "R7 command after command marks command data");
        // Write-1-to-clear and set-wins collision
        bclk = 0; tick(4); bext = 1; tick(4); bclk = 1; tick(4);
        clr_flags(3'b010); tick(1);
        chk(flags[1], 0, "R4 write-1 clears command flag");
        bext = 0; tick(2);
        clr_we = 1'b1; clr_m = 3'b010; tick(1); clr_we = 1'b0; clr_m = '0;
        chk(flags[1], 1, "R4 detection beats same-cycle clear");
        bclk = 0; tick(4); bext = 1; tick(4);

        // Master release generation with a running bus clock
        clr_flags(3'b111);
        brun = 1'b1;
        wr_ctl(5'b00001);
        chk(trig[0], 1, "R5 release trigger reads busy");
        tick(5 * BUS_HALF);
        chk(trig[0], 0, "R5 release trigger finished");
        chk(flags[0], 1, "R5 generated release detected");
        // Release then command together
        clr_flags(3'b111);
        wr_ctl(5'b00011);
        chk(trig, 2'b11, "R7 both triggers pending");
        tick(7 * BUS_HALF);
        chk(trig, 0, "R6 command trigger finished");
        chk(flags[1], 1, "R6 generated command detected");
        chk(is_addr, 1, "R7 release first gives address");

        // Acknowledge, bus clock under bench control
        brun = 1'b0; tick(1); bclk = 0; tick(6);
        wr_ctl(5'b01000);
        clr_flags(3'b111);
        pulse_done(1'b1);
        chk(pull, 1, "R8 auto acknowledge pulls line");
        chk(ready, 0, "R12 not ready during acknowledge");
        tick(4); bclk = 1; tick(6);
        chk(flags[2], 1, "R10 acknowledge detected");
        chk(pull, 1, "R8 pull held through clock high");
        bclk = 0; tick(5);
        chk(pull, 0, "R8 pull released after clock low");
        chk(ready, 1, "R12 ready after acknowledge");
        // Software acknowledge
        wr_ctl(5'b01100);
        chk(pull, 1, "R9 acknowledge trigger pulls line");
        bclk = 1; tick(5); bclk = 0; tick(5);
        chk(pull, 0, "R9 single acknowledge only");
        // No acknowledge when line stays high
        clr_flags(3'b111);
        pulse_done(1'b0);
        chk(pull, 0, "R8 no auto acknowledge for transmit");
        bclk = 1; tick(6);
        chk(flags[2], 0, "R10 high line gives no acknowledge flag");
        bclk = 0; tick(5);
        // Busy after acknowledge
        wr_ctl(5'b11000);
        pulse_done(1'b1);
        tick(3); bclk = 1; tick(5); bclk = 0; tick(5);
        chk(pull, 1, "R11 busy follows acknowledge");
        pulse_start(); tick(2);
        chk(pull, 1, "R11 start with busy enabled keeps busy");
        wr_ctl(5'b01000); tick(2);
        chk(pull, 1, "R11 clearing busy enable alone keeps busy");
        pulse_start(); tick(1);
        chk(pull, 0, "R11 busy ends on start with enable clear");
        chk(ready, 1, "R12 ready after busy");
        tick(4);
        finish_run();
    end

endmodule